// File: doc/BRIEF.md
# Configurable External Interrupt Front End

This block conditions a bank of raw interrupt pins before they reach a downstream interrupt controller. Each pin first passes through a synchroniser. The channel then either senses a level or detects an edge, and either sense has a programmable active polarity. A detected request sets a sticky bit in a raw request register. Software clears that bit by writing a one to it. A per-channel mask gates the sticky bit onto the channel's output line. Whatever trigger type a channel uses, its output line is always an active-high level.

Software reaches the configuration and status state through a small 32-bit word-addressed register bus. Writes take effect on the clock edge. Read data is a combinational decode of the address. A software-set register lets firmware raise any channel's request directly. A level-sensitive channel cannot be cleared while its input is still active: the request is set again on every cycle that the input remains active.

Top module: `ext_irq_front`

## Requirements
- R1: While reset is asserted, the mask register reads all ones, and the polarity, edge-select, source-select, raw status and masked status registers read zero. All outputs are 0.
- R2: Registers sit at byte offsets 0x00 mask, 0x04 source select, 0x08 masked status, 0x0C raw status, 0x10 clear, 0x14 polarity, 0x18 edge select and 0x1C software set. Reads of the clear and software-set offsets return 0.
- R3: A mask bit of 1 forces that channel's output to 0, and a mask bit of 0 passes the raw request. The masked status reads raw AND NOT mask, and the output vector equals the masked status.
- R4: With edge-select bit 0, the channel is level sensitive. Polarity bit 1 treats a high pin as active, and polarity bit 0 treats a low pin as active. A pin change driven before clock edge k shows in raw status after edge k+2, and the request stays latched after the pin goes inactive.
- R5: With edge-select bit 1, the channel latches a request on a rising pin edge when polarity is 1, and on a falling pin edge when polarity is 0, with the same latency as R4.
- R6: A write to the clear register clears each raw bit written as 1 and leaves bits written as 0 untouched. A request source that is active in the same cycle wins over the clear.
- R7: Clearing a level-sensitive channel whose qualified input is still active leaves its raw bit set. Once the input is inactive, the clear takes effect.
- R8: Requests latch while a channel is masked, and they show in raw status but not in masked status. Unmasking a channel later drives its output from the pending request.
- R9: Writing ones to the software-set register sets the matching raw bits on that clock edge.
- R10: The source-select register is plain read/write storage, and writing it changes neither raw status nor the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NCH (32) | Raw asynchronous interrupt pins |
| reg_addr | input | AW (5) | Byte address of the register access |
| reg_wen | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata | input | DW (32) | Write data |
| reg_rdata | output | DW (32) | Combinational read data for reg_addr |
| irq_out | output | NCH (32) | Active-high request lines to the downstream controller |

## Verification
A pin change driven before edge k reaches raw status and the outputs after edge k+2. The directed checks therefore wait two edges to confirm that nothing has appeared yet, and then one more edge to confirm the request is there. Register writes land on the single edge that samples the strobe, and read data is combinational, so the bench drives and reads on the falling edge. A bench model advances on each rising edge from the same stimulus and predicts every read and the output vector during the random phase.

// File: rtl/eiu_pkg.sv
package eiu_pkg;
   // word index (byte offset / 4) of each register; software depends on these
   localparam int unsigned K_MASK = 0;
   localparam int unsigned K_SRC  = 1;
   localparam int unsigned K_STAT = 2;
   localparam int unsigned K_RAW  = 3;
   localparam int unsigned K_CLR  = 4;
   localparam int unsigned K_POL  = 5;
   localparam int unsigned K_EDGE = 6;
   localparam int unsigned K_SWI  = 7;
endpackage

// File: rtl/eiu_sync.sv
module eiu_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/eiu_detect.sv
module eiu_detect #(
   parameter int NCH = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] smp,
   input  logic [NCH-1:0] pol,
   input  logic [NCH-1:0] edg,
   output logic [NCH-1:0] set_lvl,
   output logic [NCH-1:0] set_edge
);
   logic [NCH-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= smp;
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic act, rise, fall;
      assign act  = smp[c] ~^ pol[c];
      assign rise = smp[c] & ~prev_q[c];
      assign fall = ~smp[c] & prev_q[c];
      assign set_lvl[c]  = ~edg[c] & act;
      assign set_edge[c] = edg[c] & (pol[c] ? rise : fall);
   end
endmodule

// File: rtl/eiu_regs.sv
module eiu_regs
   import eiu_pkg::*;
#(
   parameter int NCH = 32,
   parameter int DW  = 32,
   parameter int AW  = 5
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [AW-1:0]  reg_addr,
   input  logic           reg_wen,
   input  logic [DW-1:0]  reg_wdata,
   input  logic [NCH-1:0] set_hw,
   output logic [DW-1:0]  reg_rdata,
   output logic [NCH-1:0] mask_q,
   output logic [NCH-1:0] pol_q,
   output logic [NCH-1:0] edge_q,
   output logic [NCH-1:0] raw_q
);
   localparam int IW = AW - 2;

   logic [IW-1:0]  idx;
   logic           aligned;
   logic [NCH-1:0] wd, src_q, clr_vec, swi_vec;
   logic           wr_mask, wr_src, wr_clr, wr_pol, wr_edge, wr_swi;

   assign idx     = reg_addr[AW-1:2];
   assign aligned = (reg_addr[1:0] == 2'b00);
   assign wd      = reg_wdata[NCH-1:0];

   assign wr_mask = reg_wen && aligned && (idx == IW'(K_MASK));
   assign wr_src  = reg_wen && aligned && (idx == IW'(K_SRC));
   assign wr_clr  = reg_wen && aligned && (idx == IW'(K_CLR));
   assign wr_pol  = reg_wen && aligned && (idx == IW'(K_POL));
   assign wr_edge = reg_wen && aligned && (idx == IW'(K_EDGE));
   assign wr_swi  = reg_wen && aligned && (idx == IW'(K_SWI));

   assign clr_vec = wr_clr ? wd : '0;
   assign swi_vec = wr_swi ? wd : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '1;
         src_q  <= '0;
         pol_q  <= '0;
         edge_q <= '0;
         raw_q  <= '0;
      end else begin
         if (wr_mask) mask_q <= wd;
         if (wr_src)  src_q  <= wd;
         if (wr_pol)  pol_q  <= wd;
         if (wr_edge) edge_q <= wd;
         // any active source in the same cycle outranks the clear
         raw_q <= (raw_q & ~clr_vec) | set_hw | swi_vec;
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (aligned) begin
         if      (idx == IW'(K_MASK)) reg_rdata = DW'(mask_q);
         else if (idx == IW'(K_SRC))  reg_rdata = DW'(src_q);
         else if (idx == IW'(K_STAT)) reg_rdata = DW'(raw_q & ~mask_q);
         else if (idx == IW'(K_RAW))  reg_rdata = DW'(raw_q);
         else if (idx == IW'(K_POL))  reg_rdata = DW'(pol_q);
         else if (idx == IW'(K_EDGE)) reg_rdata = DW'(edge_q);
      end
   end
endmodule

// File: rtl/ext_irq_front.sv
module ext_irq_front #(
   parameter int NCH         = 32,
   parameter int DW          = 32,
   parameter int AW          = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] irq_in,
   input  logic [AW-1:0]  reg_addr,
   input  logic           reg_wen,
   input  logic [DW-1:0]  reg_wdata,
   output logic [DW-1:0]  reg_rdata,
   output logic [NCH-1:0] irq_out
);
   if (NCH < 1 || NCH > DW) begin : g_bad_nch
      $error("ext_irq_front: NCH must be between 1 and DW");
   end
   if (AW < 5) begin : g_bad_aw
      $error("ext_irq_front: AW must cover eight word registers");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("ext_irq_front: at least two synchroniser stages required");
   end

   logic [NCH-1:0] smp, set_lvl, set_edge, set_hw;
   logic [NCH-1:0] mask_q, pol_q, edge_q, raw_q;

   eiu_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(irq_in), .q(smp)
   );

   eiu_detect #(.NCH(NCH)) u_det (
      .clk(clk), .rst_n(rst_n), .smp(smp), .pol(pol_q), .edg(edge_q),
      .set_lvl(set_lvl), .set_edge(set_edge)
   );

   assign set_hw = set_lvl | set_edge;

   eiu_regs #(.NCH(NCH), .DW(DW), .AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
      .reg_wdata(reg_wdata), .set_hw(set_hw), .reg_rdata(reg_rdata),
      .mask_q(mask_q), .pol_q(pol_q), .edge_q(edge_q), .raw_q(raw_q)
   );

   assign irq_out = raw_q & ~mask_q;
endmodule

// File: rtl/ext_irq_front_chk.sv
module ext_irq_front_chk
   import eiu_pkg::*;
#(
   parameter int NCH = 32,
   parameter int DW  = 32,
   parameter int AW  = 5
) (
   input logic           clk,
   input logic           rst_n,
   input logic [AW-1:0]  reg_addr,
   input logic           reg_wen,
   input logic [DW-1:0]  reg_wdata,
   input logic [DW-1:0]  reg_rdata,
   input logic [NCH-1:0] irq_out,
   input logic [NCH-1:0] raw_q,
   input logic [NCH-1:0] lvl_act
);
   logic [NCH-1:0] wd, clr_vec;
   logic           al, wr_clr, wr_swi, wr_mask_all, wo_addr;

   assign wd          = reg_wdata[NCH-1:0];
   assign al          = (reg_addr[1:0] == 2'b00);
   assign wr_clr      = reg_wen && al && (reg_addr[AW-1:2] == (AW-2)'(K_CLR));
   assign wr_swi      = reg_wen && al && (reg_addr[AW-1:2] == (AW-2)'(K_SWI));
   assign wr_mask_all = reg_wen && al && (reg_addr[AW-1:2] == (AW-2)'(K_MASK)) && (wd == '1);
   assign wo_addr     = al && ((reg_addr[AW-1:2] == (AW-2)'(K_CLR)) ||
                               (reg_addr[AW-1:2] == (AW-2)'(K_SWI)));
   assign clr_vec     = wr_clr ? wd : '0;

   a_r7_level_clear_held: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (($past(lvl_act) & ~raw_q) == '0));

   a_r6_drop_only_by_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (($past(raw_q) & ~raw_q & ~$past(clr_vec)) == '0));

   a_r3_mask_all_silences: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(wr_mask_all)) |-> (irq_out == '0));

   a_r9_swi_sets_raw: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(wr_swi)) |-> (($past(wd) & ~raw_q) == '0));

   a_r2_write_only_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      wo_addr |-> (reg_rdata == '0));
endmodule

bind ext_irq_front ext_irq_front_chk #(.NCH(NCH), .DW(DW), .AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
   .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out),
   .raw_q(raw_q), .lvl_act(set_lvl)
);

// File: tb/test_ext_irq_front.sv
`timescale 1ns/1ps
module test_ext_irq_front;
   localparam int NCH = 32;
   localparam logic [4:0] A_MASK = 5'h00, A_SRC = 5'h04, A_STAT = 5'h08, A_RAW = 5'h0C,
                          A_CLR = 5'h10, A_POL = 5'h14, A_EDGE = 5'h18, A_SWI = 5'h1C;

   logic            clk = 0, rst_n = 0, reg_wen = 0;
   logic [NCH-1:0]  irq_in = '0;
   logic [4:0]      reg_addr = '0;
   logic [31:0]     reg_wdata = '0, reg_rdata;
   logic [NCH-1:0]  irq_out;
   int              n_chk = 0, n_err = 0;
   bit              done = 0;
   logic [31:0]     v;

   always #2 clk = ~clk;

   ext_irq_front i_ext_irq_front (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_addr(reg_addr),
      .reg_wen(reg_wen), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
   );

   // requirement-level model, advanced on each rising edge from the same stimulus
   logic [NCH-1:0] m_s1, m_s2, m_prev, m_raw, m_mask, m_pol, m_edge, m_src;
   always @(posedge clk) begin
      logic [NCH-1:0] lvl, edg, swi, clr, wd;
      if (!rst_n) begin
         m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_raw <= '0;
         m_mask <= '1; m_pol <= '0; m_edge <= '0; m_src <= '0;
      end else begin
         wd  = reg_wdata;
         lvl = ~m_edge & ((m_s2 & m_pol) | (~m_s2 & ~m_pol));
         edg = m_edge & ((m_pol & m_s2 & ~m_prev) | (~m_pol & ~m_s2 & m_prev));
         swi = (reg_wen && reg_addr == A_SWI) ? wd : '0;
         clr = (reg_wen && reg_addr == A_CLR) ? wd : '0;
         m_raw <= (m_raw & ~clr) | lvl | edg | swi;
         if (reg_wen && reg_addr == A_MASK) m_mask <= wd;
         if (reg_wen && reg_addr == A_SRC)  m_src  <= wd;
         if (reg_wen && reg_addr == A_POL)  m_pol  <= wd;
         if (reg_wen && reg_addr == A_EDGE) m_edge <= wd;
         m_s1 <= irq_in; m_s2 <= m_s1; m_prev <= m_s2;
      end
   end

   function automatic logic [31:0] exp_rd(input logic [4:0] a);
      case (a)
         A_MASK:  return m_mask;
         A_SRC:   return m_src;
         A_STAT:  return m_raw & ~m_mask;
         A_RAW:   return m_raw;
         A_POL:   return m_pol;
         A_EDGE:  return m_edge;
         default: return '0;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      reg_addr = a; reg_wdata = d; reg_wen = 1;
      @(posedge clk); @(negedge clk);
      reg_wen = 0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      reg_addr = a; #1; d = reg_rdata;
   endtask

   initial begin
      #(4.0 * 200000);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      step(3);
      // R1 reset state
      rd(A_MASK, v); chk("R1 mask reset", v, 32'hFFFF_FFFF);
      rd(A_POL,  v); chk("R1 pol reset", v, 0);
      rd(A_EDGE, v); chk("R1 edge reset", v, 0);
      rd(A_SRC,  v); chk("R1 src reset", v, 0);
      rd(A_RAW,  v); chk("R1 raw reset", v, 0);
      rd(A_STAT, v); chk("R1 stat reset", v, 0);
      chk("R1 out reset", irq_out, 0);
      rst_n = 1;
      step(1);
      // all channels level, active high, pins low; clear what latched meanwhile
      wr(A_POL, 32'hFFFF_FFFF);
      wr(A_CLR, 32'hFFFF_FFFF);
      rd(A_RAW, v); chk("R6 clear all", v, 0);
      rd(A_CLR, v); chk("R2 clear reads zero", v, 0);
      wr(A_MASK, 32'hFFFF_FFFE);
      // R4 level high latency
      irq_in[0] = 1;
      step(2);
      rd(A_RAW, v); chk("R4 not yet after two edges", v, 0);
      step(1);
      rd(A_RAW, v); chk("R4 level latched", v, 1);
      rd(A_STAT, v); chk("R3 unmasked status", v, 1);
      chk("R3 output follows", irq_out, 1);
      // R7 clear while active
      wr(A_CLR, 32'h1);
      rd(A_RAW, v); chk("R7 clear while active held", v, 1);
      irq_in[0] = 0;
      step(3);
      rd(A_RAW, v); chk("R4 latched after release", v, 1);
      wr(A_CLR, 32'h1);
      rd(A_RAW, v); chk("R7 clear after release", v, 0);
      chk("R3 output drops", irq_out, 0);
      // R9 software set, R8 masked pending, R6 zero write
      wr(A_SWI, 32'h2);
      rd(A_RAW, v); chk("R9 software set", v, 2);
      rd(A_SWI, v); chk("R2 swi reads zero", v, 0);
      wr(A_CLR, 32'h0);
      rd(A_RAW, v); chk("R6 zero write no effect", v, 2);
      rd(A_STAT, v); chk("R8 masked not in status", v, 0);
      chk("R8 masked output low", irq_out, 0);
      wr(A_MASK, 32'h0);
      chk("R8 unmask drives pending", irq_out, 2);
      wr(A_MASK, 32'hFFFF_FFFF);
      chk("R3 mask blocks", irq_out, 0);
      wr(A_CLR, 32'h2);
      wr(A_MASK, 32'hFFFF_FFFE);
      // R5 rising edge
      wr(A_EDGE, 32'h1);
      irq_in[0] = 1;
      step(3);
      rd(A_RAW, v); chk("R5 rising latched", v, 1);
      wr(A_CLR, 32'h1);
      step(1);
      rd(A_RAW, v); chk("R5 edge clears while high", v, 0);
      // R5 falling edge
      wr(A_POL, 32'hFFFF_FFFE);
      step(1);
      rd(A_RAW, v); chk("R5 no edge from pol change", v, 0);
      irq_in[0] = 0;
      step(2);
      rd(A_RAW, v); chk("R5 falling not yet", v, 0);
      step(1);
      rd(A_RAW, v); chk("R5 falling latched", v, 1);
      wr(A_CLR, 32'h1);
      // R10 source select storage
      wr(A_SRC, 32'hA5A5_A5A5);
      rd(A_SRC, v); chk("R10 src readback", v, 32'hA5A5_A5A5);
      rd(A_RAW, v); chk("R10 src no effect raw", v, 0);
      chk("R10 src no effect out", irq_out, 0);

      // random phase against the model
      for (int i = 0; i < 3000; i++) begin
         int unsigned op;
         logic [4:0]  a;
         @(negedge clk);
         reg_wen = 0;
         irq_in = $urandom;
         op = $urandom_range(0, 7);
         a = {3'($urandom_range(0, 7)), 2'b00};
         reg_addr = a;
         #1;
         chk("R3 random output", irq_out, m_raw & ~m_mask);
         if (op < 4) begin
            chk("R2 random read", reg_rdata, exp_rd(a));
         end else begin
            reg_wdata = (op == 7) ? 32'hFFFF_FFFF : $urandom;
            reg_wen = 1;
         end
      end
      @(negedge clk);
      reg_wen = 0;
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule